// File: doc/BRIEF.md
# ULPI Clock Pin Direction Auto-Select

This block decides, without any strap or register, whether the ULPI clock pin of a USB transceiver is an input or an output. A free-running monitor clock samples the reference-clock pin through a synchronizer and counts its rising edges. If no reference clock is present, the pin stays an input. The 60 MHz link clock arriving on it then serves as the PLL reference.

When enough reference-clock edges arrive within one monitor window, the block enables the pin's output driver and moves the PLL reference to the reference-clock pin. It also picks the PLL multiplier code from the frequency-select strap (low selects 19.2 MHz, high selects 26 MHz). The strap value is captured at the moment of the decision. Output mode then holds until reset, so a later dropout or glitch on the reference clock cannot turn the pin around. Only square-wave reference clocks are expected. The PLL, the pads and any frequency measurement are outside this block.

Top module: `ulpi_clkdir_sel`

## Requirements
- R1: While and directly after reset, clk_pin_oe is 0, pll_ref_sel is 0 and pll_mult_code is 2'b00.
- R2: With refclk_pin held low, the block stays in input mode indefinitely: clk_pin_oe=0, pll_ref_sel=0 (link clock on the ULPI pin is the PLL reference), pll_mult_code=2'b00.
- R3: When EDGES_NEEDED rising edges of the synchronized refclk_pin fall into one window of WINDOW_CYCLES monitor cycles, clk_pin_oe and pll_ref_sel become 1 within SYNC_STAGES+2 monitor cycles of the last such edge reaching the pin.
- R4: Windows are counted back to back from reset release, and the edge count clears at each window boundary. Edges spread over two windows, with fewer than EDGES_NEEDED in each, never switch the mode.
- R5: In output mode pll_mult_code is 2'b01 if the captured strap was 0 (19.2 MHz), and 2'b10 if it was 1 (26 MHz).
- R6: Once output mode is entered it holds until reset, whatever refclk_pin does afterwards.
- R7: cfg_strap is sampled in the cycle output mode is declared. Later changes of cfg_strap do not change pll_mult_code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mon | input | 1 | Free-running monitor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| refclk_pin | input | 1 | Reference-clock pin level, asynchronous to clk_mon |
| cfg_strap | input | 1 | Reference frequency strap: 0 = 19.2 MHz, 1 = 26 MHz |
| clk_pin_oe | output | 1 | 1 drives the ULPI clock pin as an output |
| pll_ref_sel | output | 1 | 0 = link clock from ULPI pin, 1 = reference-clock pin |
| pll_mult_code | output | 2 | 00 link ratio, 01 19.2 MHz ratio, 10 26 MHz ratio |

## Verification
The bench sends bursts just under and exactly at the edge threshold. A block that counts off by one would switch on the short burst or miss the full one. A slow burst spreads its edges across a window boundary, which catches an edge counter that is never cleared. The bench also checks that output mode survives a reference dropout and a glitch, and that the multiplier code keeps the strap value seen at detection when the strap later flips. A design that re-evaluates either one would revert the pin direction or change the ratio.

// File: rtl/ulpi_clkdir_pkg.sv
package ulpi_clkdir_pkg;

  typedef enum logic [1:0] {
    MULT_LINK60 = 2'b00,
    MULT_REF192 = 2'b01,
    MULT_REF26  = 2'b10
  } mult_code_e;

  // PLL ratio choice: input mode uses the link clock, output mode the strap.
  function automatic mult_code_e pick_mult(input logic out_mode, input logic strap);
    if (!out_mode)  return MULT_LINK60;
    else if (strap) return MULT_REF26;
    else            return MULT_REF192;
  endfunction

endpackage

// File: rtl/clkdir_sync.sv
module clkdir_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_pulse
);
  logic [STAGES-1:0] chain;
  logic              level_d;
  logic              level;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= async_in;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], async_in};
    end
  endgenerate

  assign level = chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) level_d <= 1'b0;
    else        level_d <= level;

  assign rise_pulse = level & ~level_d;

  // A rising edge needs a low sample between, so pulses never touch (R3).
  assert_rise_isolated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rise_pulse |=> !rise_pulse);

endmodule

// File: rtl/clkdir_activity.sv
module clkdir_activity #(
  parameter int WINDOW_CYCLES = 128,
  parameter int EDGES_NEEDED  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_pulse,
  input  logic freeze,
  output logic active_det
);
  localparam int WIN_W = (WINDOW_CYCLES > 1) ? $clog2(WINDOW_CYCLES) : 1;
  localparam int CNT_W = $clog2(EDGES_NEEDED + 1);
  localparam logic [WIN_W-1:0] WIN_LAST  = WIN_W'(WINDOW_CYCLES - 1);
  localparam logic [CNT_W-1:0] EDGE_LAST = CNT_W'(EDGES_NEEDED - 1);

  logic [WIN_W-1:0] win_cnt;
  logic [CNT_W-1:0] edge_cnt;
  logic             win_end;

  assign win_end    = (win_cnt == WIN_LAST);
  assign active_det = rise_pulse && !freeze && (edge_cnt == EDGE_LAST);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       win_cnt <= '0;
    else if (freeze)  win_cnt <= win_cnt;
    else if (win_end) win_cnt <= '0;
    else              win_cnt <= win_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                        edge_cnt <= '0;
    else if (freeze)                   edge_cnt <= edge_cnt;
    else if (win_end || active_det)    edge_cnt <= '0;
    else if (rise_pulse)               edge_cnt <= edge_cnt + 1'b1;

  // The count is cleared at each window end and never reaches the target (R4).
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    edge_cnt < CNT_W'(EDGES_NEEDED));

  assert_win_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && !freeze) |=> (edge_cnt == '0));

endmodule

// File: rtl/clkdir_mode_latch.sv
module clkdir_mode_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic det,
  input  logic strap_in,
  output logic out_mode,
  output logic strap_q
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   out_mode <= 1'b0;
    else if (det) out_mode <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 strap_q <= 1'b0;
    else if (det && !out_mode)  strap_q <= strap_in;

  always @(posedge clk)
    if (!rst_n) assert_reset_input_R1: assert (out_mode == 1'b0 && strap_q == 1'b0);

  assert_enter_on_det_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_mode) |-> $past(det));

  assert_mode_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_mode |=> out_mode);

  assert_strap_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_mode |=> $stable(strap_q));

endmodule

// File: rtl/ulpi_clkdir_sel.sv
module ulpi_clkdir_sel
  import ulpi_clkdir_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int WINDOW_CYCLES = 128,
  parameter int EDGES_NEEDED  = 8
) (
  input  logic       clk_mon,
  input  logic       rst_n,
  input  logic       refclk_pin,
  input  logic       cfg_strap,
  output logic       clk_pin_oe,
  output logic       pll_ref_sel,
  output logic [1:0] pll_mult_code
);
  logic ref_rise;
  logic ref_active;
  logic out_mode;
  logic strap_q;

  clkdir_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk_mon),
    .rst_n      (rst_n),
    .async_in   (refclk_pin),
    .rise_pulse (ref_rise)
  );

  clkdir_activity #(
    .WINDOW_CYCLES (WINDOW_CYCLES),
    .EDGES_NEEDED  (EDGES_NEEDED)
  ) u_act (
    .clk        (clk_mon),
    .rst_n      (rst_n),
    .rise_pulse (ref_rise),
    .freeze     (out_mode),
    .active_det (ref_active)
  );

  clkdir_mode_latch u_latch (
    .clk      (clk_mon),
    .rst_n    (rst_n),
    .det      (ref_active),
    .strap_in (cfg_strap),
    .out_mode (out_mode),
    .strap_q  (strap_q)
  );

  assign clk_pin_oe    = out_mode;
  assign pll_ref_sel   = out_mode;
  assign pll_mult_code = pick_mult(out_mode, strap_q);

  assert_code_legal_R5: assert property (@(posedge clk_mon) disable iff (!rst_n)
    clk_pin_oe ? (pll_mult_code inside {2'b01, 2'b10}) : (pll_mult_code == 2'b00));

  assert_input_mode_R2: assert property (@(posedge clk_mon) disable iff (!rst_n)
    !pll_ref_sel |-> !clk_pin_oe);

endmodule

// File: tb/ulpi_clkdir_sel_tb.sv
module ulpi_clkdir_sel_tb;
  localparam int WIN = 128;
  localparam int NEED = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic refclk = 1'b0;
  logic cfg = 1'b0;
  logic oe, rsel;
  logic [1:0] code;
  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  ulpi_clkdir_sel #(.SYNC_STAGES(2), .WINDOW_CYCLES(WIN), .EDGES_NEEDED(NEED)) u_dut (
    .clk_mon(clk), .rst_n(rst_n), .refclk_pin(refclk), .cfg_strap(cfg),
    .clk_pin_oe(oe), .pll_ref_sel(rsel), .pll_mult_code(code));

  typedef struct packed {
    logic [7:0] half;
    logic [7:0] edges;
    logic       strap;
    logic       exp_oe;
    logic [1:0] exp_code;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{8'd3,  8'd8,  1'b0, 1'b1, 2'b01},  // R3 R5 exact threshold, 19.2
    '{8'd3,  8'd8,  1'b1, 1'b1, 2'b10},  // R3 R5 exact threshold, 26
    '{8'd3,  8'd7,  1'b1, 1'b0, 2'b00},  // R4 one short
    '{8'd10, 8'd8,  1'b0, 1'b0, 2'b00},  // R4 split over two windows
    '{8'd5,  8'd12, 1'b0, 1'b1, 2'b01},  // R3 R5 longer burst
    '{8'd1,  8'd8,  1'b1, 1'b1, 2'b10}   // R3 R5 fastest sampled toggle
  };

  function automatic logic [1:0] want_code(input logic o, input logic s);
    if (!o) return 2'b00;
    return s ? 2'b10 : 2'b01;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    refclk = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
  endtask

  task automatic toggle(input int half, input int edges);
    for (int i = 0; i < edges; i++) begin
      refclk = 1'b1;
      wait_cyc(half);
      refclk = 1'b0;
      wait_cyc(half);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state, during and after reset
    wait_cyc(2);
    check("R1", "oe in reset", oe, 0);
    check("R1", "code in reset", code, 0);
    do_reset();
    wait_cyc(1);
    check("R1", "oe after reset", oe, 0);
    check("R1", "ref_sel after reset", rsel, 0);
    check("R1", "code after reset", code, 0);

    // R2: reference held low for many windows
    wait_cyc(6 * WIN);
    check("R2", "oe idle", oe, 0);
    check("R2", "ref_sel idle", rsel, 0);
    check("R2", "code idle", code, 0);

    foreach (VECS[k]) begin
      cfg = VECS[k].strap;
      do_reset();
      toggle(VECS[k].half, VECS[k].edges);
      wait_cyc(8);
      check(VECS[k].exp_oe ? "R3" : "R4", $sformatf("oe vec%0d", k), oe, VECS[k].exp_oe);
      check(VECS[k].exp_oe ? "R3" : "R4", $sformatf("ref_sel vec%0d", k), rsel, VECS[k].exp_oe);
      check("R5", $sformatf("code vec%0d", k), code, want_code(VECS[k].exp_oe, VECS[k].strap));
      check("R5", $sformatf("table code vec%0d", k), code, VECS[k].exp_code);
    end

    // R3: switch comes within SYNC_STAGES+2 cycles of the last needed edge
    cfg = 1'b0;
    do_reset();
    toggle(2, NEED - 1);
    refclk = 1'b1;
    wait_cyc(4);
    check("R3", "oe latency", oe, 1);

    // R6: dropout and glitch after entry do not revert
    refclk = 1'b0;
    wait_cyc(3 * WIN);
    check("R6", "oe after dropout", oe, 1);
    refclk = 1'b1; wait_cyc(1); refclk = 1'b0;
    wait_cyc(10);
    check("R6", "oe after glitch", oe, 1);
    check("R6", "ref_sel after glitch", rsel, 1);

    // R7: strap flips after detection; code keeps the captured value
    cfg = 1'b1;
    wait_cyc(10);
    check("R7", "code after strap flip", code, 2'b01);
    toggle(3, 10);
    wait_cyc(5);
    check("R7", "code after more edges", code, 2'b01);

    // R1: a new reset returns to input mode
    do_reset();
    wait_cyc(1);
    check("R1", "oe after re-reset", oe, 0);
    check("R1", "code after re-reset", code, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule